// File: doc/BRIEF.md
# Reset-Action Command Handler for a Serial Bus Target

This block sits behind the command decoder of a serial bus target and handles the reset-action common command. The decoder delivers one event per received defining byte. Each event has a one-cycle valid strobe, a command kind (broadcast write, direct write or direct read), an "addressed to this target" qualifier for direct kinds, and the defining byte itself. The handler answers each event it takes with an ACK or NACK decision. For direct reads it also supplies the data byte to return.

The handler keeps an action register that software reads and writes. The register holds the last defining byte received by any write kind, whether or not that byte is supported. After reset it holds the default action 0x01 (reset the peripheral only). Software can restore that default by writing 0xFF. A one-cycle event tells software that the bus has stored a new action. The handler does not detect the reset pattern and does not perform any reset.

Top module: `reset_action_ccc`

## Requirements
- R1: After reset the action register reads 0x01, and the response-valid and action-update outputs are low.
- R2: Command kind encoding is 2'b00 broadcast write, 2'b01 direct write and 2'b10 direct read. A taken event produces a response one clock after its valid strobe. Write events with defining byte 0x00, 0x01 or 0x02, and with any byte outside the refused set, are ACKed.
- R3: Defining bytes 0x03, 0x04, 0x83 and 0x84 form the refused set. They are NACKed on writes and on direct reads.
- R4: A direct read with defining byte 0x00, 0x01 or 0x02 is ACKed and returns the current action register value, not the defining byte. A read never changes the register.
- R5: A direct read with any other byte outside the refused set (0x05 to 0x82 and 0x85 to 0xFF) is ACKed and returns 0xFF.
- R6: Every defining byte of a taken write is stored in the action register on the edge after its strobe, refused bytes included. The action-update output pulses high for that one cycle.
- R7: A software write of 0xFF restores the register to 0x01. Any other software value is stored as written, one edge after the write enable.
- R8: If a taken bus write and a software write fall in the same cycle, the bus byte is stored.
- R9: A direct event whose qualifier is low, or any event of reserved kind 2'b11, is ignored: no response, no store and no update pulse. Broadcast writes are taken whatever the qualifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Defining-byte-valid strobe, one cycle per event |
| cmd_kind | input | 2 | Event kind: 00 broadcast write, 01 direct write, 10 direct read, 11 reserved |
| cmd_for_me | input | 1 | Direct event addresses this target |
| cmd_byte | input | 8 | Defining byte |
| sw_we | input | 1 | Software write enable for the action register |
| sw_wdata | input | 8 | Software write data |
| act_q | output | 8 | Action register value |
| act_upd | output | 1 | One-cycle pulse when a bus write stored a byte |
| rsp_vld | output | 1 | Response valid, one cycle after a taken event |
| rsp_ack | output | 1 | 1 = ACK, 0 = NACK |
| rsp_data | output | 8 | Read data for direct reads (0xFF unless a readback) |

## Verification
The assertions assume that `cmd_vld` is a single-cycle strobe and that `cmd_kind`, `cmd_for_me` and `cmd_byte` are valid whenever it is high. They also assume that `sw_we` and `sw_wdata` are never unknown after reset. The bench drives every event for exactly one clock from the falling edge, then drops the strobe. It only changes the qualifier and byte while the strobe is high, and it holds the software inputs low outside its software-write scenarios. Outputs are sampled on the falling edge that follows the capturing rising edge.

// File: rtl/reset_action_pkg.sv
package reset_action_pkg;
  typedef enum logic [1:0] {
    CMD_BCAST_WR = 2'b00,
    CMD_DIR_WR   = 2'b01,
    CMD_DIR_RD   = 2'b10,
    CMD_RSVD     = 2'b11
  } cmd_kind_e;

  typedef struct packed {
    logic refused;
    logic readback;
  } byte_class_t;
endpackage

// File: rtl/ra_byte_classify.sv
module ra_byte_classify
  import reset_action_pkg::*;
#(
  parameter int W = 8,
  parameter int LAST_ACTION = 2
) (
  input  logic [W-1:0] def_byte,
  output byte_class_t  cls
);
  localparam logic [W-1:0] LAST_A  = W'(LAST_ACTION);
  localparam logic [W-1:0] REF_A   = W'(LAST_ACTION + 1);
  localparam logic [W-1:0] REF_B   = W'(LAST_ACTION + 2);
  localparam logic [W-1:0] TIME_HI = W'(1) << (W - 1);

  always_comb begin
    cls.readback = (def_byte <= LAST_A);
    cls.refused  = (def_byte == REF_A) || (def_byte == REF_B) ||
                   (def_byte == (TIME_HI | REF_A)) ||
                   (def_byte == (TIME_HI | REF_B));
  end
endmodule

// File: rtl/ra_action_reg.sv
module ra_action_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] DEF_ACTION = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_we,
  input  logic [W-1:0] bus_byte,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] act_q,
  output logic         upd_q
);
  localparam logic [W-1:0] CLEAR_CODE = '1;

  logic [W-1:0] act_d;
  logic         act_en;

  always_comb begin
    act_en = bus_we | sw_we;
    act_d  = act_q;
    if (bus_we)
      act_d = bus_byte;
    else if (sw_we)
      act_d = (sw_wdata == CLEAR_CODE) ? DEF_ACTION : sw_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= DEF_ACTION;
      upd_q <= 1'b0;
    end else begin
      if (act_en) act_q <= act_d;
      upd_q <= bus_we;
    end
  end

  // R6
  bus_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> (upd_q && act_q == $past(bus_byte)));
  // R7
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_we && !bus_we && sw_wdata == CLEAR_CODE) |=> (act_q == DEF_ACTION));
  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !sw_we) |=> ($stable(act_q) && !upd_q));
endmodule

// File: rtl/ra_response.sv
module ra_response #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic         is_read,
  input  logic         refused,
  input  logic         readback,
  input  logic [W-1:0] act_q,
  output logic         rsp_vld,
  output logic         rsp_ack,
  output logic [W-1:0] rsp_data
);
  localparam logic [W-1:0] FILL = '1;

  logic         vld_d, ack_d;
  logic [W-1:0] data_d;

  always_comb begin
    vld_d  = take;
    ack_d  = take & ~refused;
    data_d = FILL;
    if (take && is_read && readback) data_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_ack  <= 1'b0;
      rsp_data <= FILL;
    end else begin
      rsp_vld <= vld_d;
      rsp_ack <= ack_d;
      if (take) rsp_data <= data_d;
    end
  end

  // R2
  rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(take));
endmodule

// File: rtl/reset_action_ccc.sv
module reset_action_ccc
  import reset_action_pkg::*;
#(
  parameter int W = 8,
  parameter int LAST_ACTION = 2,
  parameter logic [W-1:0] DEF_ACTION = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_vld,
  input  logic [1:0]   cmd_kind,
  input  logic         cmd_for_me,
  input  logic [W-1:0] cmd_byte,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  output logic [W-1:0] act_q,
  output logic         act_upd,
  output logic         rsp_vld,
  output logic         rsp_ack,
  output logic [W-1:0] rsp_data
);
  localparam logic [W-1:0] FILL = '1;

  cmd_kind_e   kind;
  byte_class_t cls;
  logic        is_bcast, is_direct, is_read, take, bus_we;

  always_comb begin
    kind      = cmd_kind_e'(cmd_kind);
    is_bcast  = (kind == CMD_BCAST_WR);
    is_direct = (kind == CMD_DIR_WR) || (kind == CMD_DIR_RD);
    is_read   = (kind == CMD_DIR_RD);
    take      = cmd_vld && (is_bcast || (is_direct && cmd_for_me));
    bus_we    = take && !is_read;
  end

  ra_byte_classify #(.W(W), .LAST_ACTION(LAST_ACTION)) u_cls (
    .def_byte (cmd_byte),
    .cls      (cls)
  );

  ra_action_reg #(.W(W), .DEF_ACTION(DEF_ACTION)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .bus_byte (cmd_byte),
    .sw_we    (sw_we),
    .sw_wdata (sw_wdata),
    .act_q    (act_q),
    .upd_q    (act_upd)
  );

  ra_response #(.W(W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .is_read  (is_read),
    .refused  (cls.refused),
    .readback (cls.readback),
    .act_q    (act_q),
    .rsp_vld  (rsp_vld),
    .rsp_ack  (rsp_ack),
    .rsp_data (rsp_data)
  );

  // R3
  refuse_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cls.refused) |=> (rsp_vld && !rsp_ack));
  // R5
  fill_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_read && !cls.refused && !cls.readback) |=>
      (rsp_ack && rsp_data == FILL));
  // R4
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && is_read && cls.readback) |=> (rsp_ack && rsp_data == $past(act_q)));
  // R9
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !take && !sw_we) |=> (!rsp_vld && !act_upd && $stable(act_q)));
endmodule

// File: tb/sim_reset_action_ccc.sv
module sim_reset_action_ccc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_vld, cmd_for_me, sw_we;
  logic [1:0] cmd_kind;
  logic [7:0] cmd_byte, sw_wdata;
  logic [7:0] act_q, rsp_data;
  logic       act_upd, rsp_vld, rsp_ack;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  reset_action_ccc u0 (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_kind(cmd_kind),
    .cmd_for_me(cmd_for_me), .cmd_byte(cmd_byte), .sw_we(sw_we),
    .sw_wdata(sw_wdata), .act_q(act_q), .act_upd(act_upd),
    .rsp_vld(rsp_vld), .rsp_ack(rsp_ack), .rsp_data(rsp_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one event for one cycle; on return the registered outputs are visible.
  task automatic send(input logic [1:0] k, input logic me, input logic [7:0] b);
    @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = k; cmd_for_me = me; cmd_byte = b;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic sw_write(input logic [7:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 act", act_q, 8'h01);
    chk("R1 rsp_vld", rsp_vld, 0);
    chk("R1 act_upd", act_upd, 0);
  endtask

  task automatic t_write_supported;
    send(2'b00, 1'b0, 8'h00);
    chk("R2 bcast vld", rsp_vld, 1); chk("R2 bcast ack", rsp_ack, 1);
    chk("R6 bcast store", act_q, 8'h00); chk("R6 upd", act_upd, 1);
    @(negedge clk);
    chk("R6 upd one cycle", act_upd, 0); chk("R2 vld one cycle", rsp_vld, 0);
    send(2'b01, 1'b1, 8'h02);
    chk("R2 direct ack", rsp_ack, 1); chk("R6 direct store", act_q, 8'h02);
    send(2'b00, 1'b1, 8'h01);
    chk("R2 bcast 01 ack", rsp_ack, 1); chk("R6 store 01", act_q, 8'h01);
  endtask

  task automatic t_read_back;
    send(2'b10, 1'b1, 8'h01);
    chk("R4 ack", rsp_ack, 1); chk("R4 data", rsp_data, 8'h01);
    chk("R4 no upd", act_upd, 0);
    send(2'b00, 1'b0, 8'h00);
    send(2'b10, 1'b1, 8'h02);
    chk("R4 data is register", rsp_data, 8'h00);
    chk("R4 read keeps reg", act_q, 8'h00);
  endtask

  task automatic t_refused;
    send(2'b00, 1'b0, 8'h03);
    chk("R3 wr 03 vld", rsp_vld, 1); chk("R3 wr 03 nack", rsp_ack, 0);
    chk("R6 refused stored", act_q, 8'h03);
    send(2'b01, 1'b1, 8'h04);
    chk("R3 wr 04 nack", rsp_ack, 0);
    send(2'b10, 1'b1, 8'h84);
    chk("R3 rd 84 nack", rsp_ack, 0);
    send(2'b10, 1'b1, 8'h03);
    chk("R3 rd 03 nack", rsp_ack, 0);
    send(2'b01, 1'b1, 8'h83);
    chk("R3 wr 83 nack", rsp_ack, 0); chk("R6 83 stored", act_q, 8'h83);
  endtask

  task automatic t_read_fill;
    logic [7:0] codes [6] = '{8'h81, 8'h82, 8'h85, 8'h10, 8'h80, 8'hFF};
    foreach (codes[i]) begin
      send(2'b10, 1'b1, codes[i]);
      chk($sformatf("R5 ack %0h", codes[i]), rsp_ack, 1);
      chk($sformatf("R5 data %0h", codes[i]), rsp_data, 8'hFF);
    end
    chk("R5 reg kept", act_q, 8'h83);
  endtask

  task automatic t_store_any;
    send(2'b01, 1'b1, 8'h40);
    chk("R2 wr 40 ack", rsp_ack, 1); chk("R6 store 40", act_q, 8'h40);
    send(2'b00, 1'b0, 8'hC7);
    chk("R6 store C7", act_q, 8'hC7);
  endtask

  task automatic t_software;
    sw_write(8'h5A);
    chk("R7 sw store", act_q, 8'h5A); chk("R7 sw no upd", act_upd, 0);
    sw_write(8'hFF);
    chk("R7 sw clear", act_q, 8'h01);
  endtask

  task automatic t_collide;
    @(negedge clk);
    cmd_vld = 1'b1; cmd_kind = 2'b00; cmd_for_me = 1'b0; cmd_byte = 8'h02;
    sw_we = 1'b1; sw_wdata = 8'h33;
    @(negedge clk);
    cmd_vld = 1'b0; sw_we = 1'b0;
    chk("R8 bus wins", act_q, 8'h02);
  endtask

  task automatic t_ignore;
    send(2'b01, 1'b0, 8'h00);
    chk("R9 dir wr vld", rsp_vld, 0); chk("R9 dir wr upd", act_upd, 0);
    chk("R9 dir wr reg", act_q, 8'h02);
    send(2'b10, 1'b0, 8'h81);
    chk("R9 dir rd vld", rsp_vld, 0);
    send(2'b11, 1'b1, 8'h00);
    chk("R9 rsvd vld", rsp_vld, 0); chk("R9 rsvd reg", act_q, 8'h02);
    send(2'b00, 1'b0, 8'h00);
    chk("R9 bcast taken", act_q, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; cmd_vld = 1'b0; cmd_kind = 2'b00; cmd_for_me = 1'b0;
    cmd_byte = 8'h00; sw_we = 1'b0; sw_wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_supported();
    t_read_back();
    t_refused();
    t_read_fill();
    t_store_any();
    t_software();
    t_collide();
    t_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule